// File: doc/BRIEF.md
# Slot-Array Queue Lock

This block is a hardware mutual-exclusion lock shared by a fixed set of requesters. It keeps a circular array of slots, and each slot holds one token bit. Exactly one token bit is set at any time. A requester that asks for the lock takes the next free slot index in one step, and from then on it looks only at the token bit of its own slot. It holds the lock while that bit is set.

When the holder gives the lock up, the block clears the holder's token bit and sets the bit of the slot that follows it in circular order. Only the requester waiting on that slot wakes, so every acquisition costs the same small, fixed amount of work however many requesters wait. The price is storage: the block needs one slot per requester that can wait, so the slot count must be at least the requester count.

A requester raises its `acq_req` bit for one cycle to join the queue. It waits for its `grant` bit, keeps the lock while `grant` stays high, and raises its `rel_req` bit for one cycle to pass the lock on.

Top module: `array_queue_lock`

## Requirements
- R1: After reset no requester is granted, and the token bit of slot 0 is the only one set, so the first requester to ask takes slot 0 and is granted without waiting.
- R2: An `acq_req` pulse from an idle requester whose slot holds the token makes its `grant` bit high from the next clock edge.
- R3: Idle requesters that ask in different cycles get consecutive slots and are granted in the order they asked.
- R4: When several idle requesters ask in the same cycle, they get consecutive slots in increasing requester index, so the lowest index is served first.
- R5: At most one `grant` bit is high in any cycle.
- R6: A `rel_req` pulse from the holder drops its `grant` at the next edge and, in that same edge, grants the requester waiting on the following slot, if any. A requester that asks in the same cycle as a release joins the queue in the normal way.
- R7: A `rel_req` pulse from a requester that does not hold the lock has no effect on any `grant` bit.
- R8: An `acq_req` pulse from a requester that is already waiting or holding is ignored and takes no slot, so the order of later grants does not change.
- R9: A granted requester keeps its `grant` high until it releases.
- R10: Slot indices wrap from NSLOT-1 back to 0, both when slots are handed out and when the token moves on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| acq_req | input | NREQ | One-cycle pulse per requester to join the queue |
| rel_req | input | NREQ | One-cycle pulse per requester to give the lock up |
| grant | output | NREQ | High while the requester holds the lock |

## Verification
The bench first sends one request alone, to confirm the reset token position and the one-cycle grant delay. It then sends three requests in the same cycle, which tells fixed index order apart from any other order. It sends duplicate requests and releases from requesters that do not hold the lock, to show that both leave the queue unchanged. After enough acquisitions for the slot index to wrap past NSLOT-1, the grant order shows whether the token and the allocator move around the ring together. A final case puts a release and a new request in the same cycle, which separates a correct handoff from one that loses the request or the token.

// File: rtl/array_queue_lock.sv
module array_queue_lock #(
  parameter int NREQ  = 4,
  parameter int NSLOT = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NREQ-1:0] acq_req,
  input  logic [NREQ-1:0] rel_req,
  output logic [NREQ-1:0] grant
);
  localparam int SW = (NSLOT > 1) ? $clog2(NSLOT) : 1;

  logic [NSLOT-1:0] flag;
  logic [SW-1:0]    tail, tail_nxt, hslot, succ;
  logic [NREQ-1:0]  busy, take, done;
  logic [SW-1:0]    slot     [NREQ];
  logic [SW-1:0]    new_slot [NREQ];

  function automatic logic [SW-1:0] wrap_add(input logic [SW-1:0] base, input int add);
    int s;
    s = int'(base) + add;
    return SW'(s % NSLOT);
  endfunction

  assign take = acq_req & ~busy;
  assign done = rel_req & grant;

  always_comb begin
    int off;
    off = 0;
    for (int i = 0; i < NREQ; i++) begin
      new_slot[i] = wrap_add(tail, off);
      if (take[i]) off = off + 1;
    end
    tail_nxt = wrap_add(tail, off);
  end

  always_comb begin
    hslot = '0;
    for (int i = 0; i < NREQ; i++)
      if (done[i]) hslot = slot[i];
  end

  assign succ = wrap_add(hslot, 1);

  genvar g;
  generate
    for (g = 0; g < NREQ; g++) begin : g_grant
      assign grant[g] = busy[g] & flag[slot[g]];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag <= NSLOT'(1);
      tail <= '0;
      busy <= '0;
      for (int i = 0; i < NREQ; i++) slot[i] <= '0;
    end else begin
      tail <= tail_nxt;
      busy <= (busy | take) & ~done;
      for (int i = 0; i < NREQ; i++)
        if (take[i]) slot[i] <= new_slot[i];
      if (|done)
        flag <= (flag & ~(NSLOT'(1) << hslot)) | (NSLOT'(1) << succ);
    end
  end
endmodule

module array_queue_lock_chk #(
  parameter int NREQ  = 4,
  parameter int NSLOT = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NREQ-1:0]  acq_req,
  input logic [NREQ-1:0]  rel_req,
  input logic [NREQ-1:0]  grant,
  input logic [NREQ-1:0]  busy,
  input logic [NSLOT-1:0] flag
);
  assert_single_token_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(flag));

  assert_one_holder_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  assert_handoff_drops_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((rel_req & grant) != '0) |=> ((grant & $past(rel_req & grant)) == '0));

  assert_stray_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (((rel_req & grant) == '0) && ((acq_req & ~busy) == '0)) |=> $stable(grant));

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((grant & ~rel_req) != '0) |=> ((grant & $past(grant & ~rel_req)) == $past(grant & ~rel_req)));
endmodule

bind array_queue_lock array_queue_lock_chk #(.NREQ(NREQ), .NSLOT(NSLOT)) u_chk (
  .clk(clk), .rst_n(rst_n), .acq_req(acq_req), .rel_req(rel_req),
  .grant(grant), .busy(busy), .flag(flag)
);

// File: tb/array_queue_lock_test.sv
module array_queue_lock_test;
  localparam int NREQ   = 4;
  localparam int NSLOT  = 4;
  localparam time TCLK  = 10ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NREQ-1:0] acq_req = '0;
  logic [NREQ-1:0] rel_req = '0;
  logic [NREQ-1:0] grant;

  int checks = 0;
  int fails  = 0;
  int expq[$];
  logic [NREQ-1:0] bbusy = '0;
  logic [NREQ-1:0] prev_g = '0;

  array_queue_lock #(.NREQ(NREQ), .NSLOT(NSLOT)) uut (
    .clk(clk), .rst_n(rst_n), .acq_req(acq_req), .rel_req(rel_req), .grant(grant)
  );

  always #(TCLK/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_acq(input logic [NREQ-1:0] mask);
    @(negedge clk);
    acq_req = mask;
    for (int i = 0; i < NREQ; i++)
      if (mask[i] && !bbusy[i]) begin
        expq.push_back(i);
        bbusy[i] = 1'b1;
      end
    @(negedge clk);
    acq_req = '0;
  endtask

  task automatic do_rel(input int id);
    @(negedge clk);
    rel_req[id] = 1'b1;
    @(negedge clk);
    rel_req = '0;
    bbusy[id] = 1'b0;
  endtask

  task automatic rel_and_acq(input int rid, input int aid);
    @(negedge clk);
    rel_req[rid] = 1'b1;
    acq_req[aid] = 1'b1;
    expq.push_back(aid);
    bbusy[aid] = 1'b1;
    @(negedge clk);
    rel_req = '0;
    acq_req = '0;
    bbusy[rid] = 1'b0;
  endtask

  // Scoreboard monitor: every newly raised grant must be the next expected id (R3, R4, R5)
  always @(negedge clk) begin
    if (rst_n) begin
      logic [NREQ-1:0] rise;
      rise = grant & ~prev_g;
      if ($countones(grant) > 1)
        check(1'b0, "R5 one holder", int'(grant), 0);
      if (rise != '0) begin
        int id;
        id = -1;
        for (int i = 0; i < NREQ; i++) if (rise[i]) id = i;
        if (expq.size() == 0)
          check(1'b0, "R3 unexpected grant", id, -1);
        else begin
          int e;
          e = expq.pop_front();
          check(id == e, "R3/R4 grant order", id, e);
        end
      end
      prev_g = grant;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(grant == '0, "R1 no grant after reset", int'(grant), 0);

    do_acq(4'b0001);
    check(grant == 4'b0001, "R1/R2 first requester granted at once", int'(grant), 1);

    do_acq(4'b1110);
    check(grant == 4'b0001, "R4 waiters not granted", int'(grant), 1);
    repeat (3) @(negedge clk);
    check(grant == 4'b0001, "R9 grant held", int'(grant), 1);

    do_acq(4'b0011);
    check(grant == 4'b0001, "R8 duplicate request ignored", int'(grant), 1);
    do_rel(2);
    check(grant == 4'b0001, "R7 stray release ignored", int'(grant), 1);

    do_rel(0);
    check(grant == 4'b0010, "R6 handoff to next slot", int'(grant), 2);
    do_acq(4'b0001);
    check(grant == 4'b0010, "R3 late requester waits", int'(grant), 2);
    do_rel(1);
    check(grant == 4'b0100, "R6 handoff", int'(grant), 4);
    do_rel(2);
    check(grant == 4'b1000, "R6 handoff", int'(grant), 8);
    do_rel(3);
    check(grant == 4'b0001, "R10 token wraps to slot 0", int'(grant), 1);
    do_rel(0);
    check(grant == 4'b0000, "R6 release with no waiter", int'(grant), 0);

    do_acq(4'b1111);
    check(grant == 4'b0001, "R4/R10 lowest index gets wrapped slot", int'(grant), 1);
    do_rel(0);
    check(grant == 4'b0010, "R4 order 1", int'(grant), 2);
    do_rel(1);
    check(grant == 4'b0100, "R4 order 2", int'(grant), 4);
    do_rel(2);
    check(grant == 4'b1000, "R4 order 3", int'(grant), 8);
    rel_and_acq(3, 0);
    check(grant == 4'b0001, "R6 release and request in same cycle", int'(grant), 1);
    do_rel(0);
    check(grant == 4'b0000, "R6 final release", int'(grant), 0);

    repeat (2) @(negedge clk);
    check(expq.size() == 0, "R3 all expected grants seen", expq.size(), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule